// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 32-word by 36-bit first-in first-out buffer with independent write and read clocks. Alongside the usual full and empty indications it drives two active-low warning outputs. `pae_n` warns that the buffer is nearly drained, and `paf_n` warns that it is nearly out of space. Each compares an occupancy figure against an offset register. Both offsets are loaded from parameters (default 7) while master reset is high. The write and read pointers cross between the clock domains as Gray code through two-flop synchronizers.

While master reset is high, the block samples a timing-mode input and holds that choice until the next master reset. In split-edge mode each warning is raised by an edge of one clock and withdrawn by an edge of the other. The warning is raised in the domain whose activity moves toward the threshold, and it is withdrawn in the domain whose activity moves away from it. In single-domain mode each warning is a register clocked only by its own domain: read clock for the drain warning, write clock for the space warning. Activity in the other domain reaches it only after the pointer crossing.

Top module: `tflag_fifo`

## Requirements
- R1: While `mrst` is high and on the first cycle after it, `empty`=1, `full`=0, `pae_n`=0 and `paf_n`=1.
- R2: Words are read in the order they were written, with all 36 bits intact. A word appears on `rd_data` at the rising `rclk` edge that accepts the read (`rd_en`=1 and `empty`=0).
- R3: After 32 unread writes `full`=1. A write while `full`=1 is dropped, and the stored 32 words are later read back unchanged.
- R4: A read while `empty`=1 is dropped: `rd_data` keeps its value, `empty` stays 1, and the next written word is the next word read.
- R5: Once both pointers have crossed, `pae_n`=0 when the stored word count is 7 or less (the empty offset) and `pae_n`=1 when it is 8 or more.
- R6: Once both pointers have crossed, `paf_n`=0 when the free space (32 minus the count) is 7 or less (the full offset) and `paf_n`=1 otherwise.
- R7: `flag_mode` is sampled while `mrst`=1 (0 selects split-edge mode, 1 selects single-domain mode). Changes to it after reset have no effect.
- R8: In split-edge mode, `pae_n` falls right after the `rclk` edge of the read that brings the count down to the empty offset. It rises right after the `wclk` edge of the write that lifts the count above that offset. `paf_n` falls right after the `wclk` edge of the write that cuts the free space to the full offset, and it rises right after the `rclk` edge of the read that lifts the free space above it.
- R9: In single-domain mode, `pae_n` changes only on `rclk` and `paf_n` only on `wclk`. A write that lifts the count above the empty offset therefore leaves `pae_n` low until the read side has seen the new write pointer. A read that lifts the free space above the full offset leaves `paf_n` low until the write side has seen the new read pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, sampled synchronously by both clocks |
| flag_mode | input | 1 | Warning timing select, sampled during reset (0 split-edge, 1 single-domain) |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| full | output | 1 | No free entry; writes are dropped |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Word read, registered on `rclk` |
| empty | output | 1 | No stored word; reads are dropped |
| pae_n | output | 1 | Nearly-empty warning, active low |
| paf_n | output | 1 | Nearly-full warning, active low |

## Verification
The hardest situation to reach is the one that tells the two timing modes apart: the single `wclk` or `rclk` edge on which a warning moves. Just after that edge, the other domain has not yet received the pointer change. The stimulus brings the occupancy one word short of a threshold, waits until both pointers have crossed, and then issues the single write or read that crosses it. The bench samples the warning one nanosecond after that edge. The two clocks have unrelated periods. At that sample point, split-edge mode must already show the change, and single-domain mode must not show it until several cycles of the other clock have passed.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
  typedef enum logic {
    FLAG_SPLIT  = 1'b0,
    FLAG_SINGLE = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/tf_sync.sv
module tf_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tf_ram.sv
module tf_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tf_xflag.sv
// Warning that is raised by one clock and withdrawn by another. Each side
// owns a toggle; the warning is active while the toggles differ. A side only
// toggles once it has seen the other side's last toggle, so the two never race.
module tf_xflag #(
  parameter logic INIT_ACTIVE = 1'b0
) (
  input  logic s_clk,
  input  logic s_rst,
  input  logic s_cond_i,
  input  logic c_clk,
  input  logic c_rst,
  input  logic c_cond_i,
  output logic active_o
);
  logic s_tgl_q, c_tgl_q, c_seen, s_seen;

  tf_sync #(.W(1), .RST_VAL(1'b0)) u_c_to_s (
    .clk(s_clk), .rst(s_rst), .d_i(c_tgl_q), .q_o(c_seen)
  );
  tf_sync #(.W(1), .RST_VAL(INIT_ACTIVE)) u_s_to_c (
    .clk(c_clk), .rst(c_rst), .d_i(s_tgl_q), .q_o(s_seen)
  );

  always_ff @(posedge s_clk) begin
    if (s_rst)                            s_tgl_q <= INIT_ACTIVE;
    else if (s_cond_i && (s_tgl_q == c_seen)) s_tgl_q <= ~s_tgl_q;
  end

  always_ff @(posedge c_clk) begin
    if (c_rst)                            c_tgl_q <= 1'b0;
    else if (c_cond_i && (s_seen != c_tgl_q)) c_tgl_q <= ~c_tgl_q;
  end

  assign active_o = s_tgl_q ^ c_tgl_q;
endmodule

// File: rtl/tf_wr_ctl.sv
module tf_wr_ctl
  import tflag_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int AE_OFS = 7,
  parameter int AF_OFS = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_i,
  output logic          full_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          paf_set_o,
  output logic          pae_clr_o,
  output logic          paf_reg_n_o,
  output flag_mode_e    mode_o
);
  logic [PW-1:0] wptr_q, wgray_q, rbin, wptr_nxt, cnt_nxt, free_nxt;
  logic [PW-1:0] ae_ofs_q, af_ofs_q;
  logic          paf_q, push;
  flag_mode_e    mode_q;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_i >> i);
    full_o   = (wptr_q - rbin) == PW'(DEPTH);
    push     = wr_en_i && !full_o;
    wptr_nxt = wptr_q + PW'(push);
    cnt_nxt  = wptr_nxt - rbin;
    free_nxt = PW'(DEPTH) - cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      wgray_q  <= '0;
      paf_q    <= 1'b1;
      mode_q   <= flag_mode_e'(mode_i);
      ae_ofs_q <= PW'(AE_OFS);
      af_ofs_q <= PW'(AF_OFS);
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      paf_q   <= !(free_nxt <= af_ofs_q);
    end
  end

  assign we_o        = push;
  assign waddr_o     = wptr_q[AW-1:0];
  assign wgray_o     = wgray_q;
  assign paf_set_o   = free_nxt <= af_ofs_q;
  assign pae_clr_o   = cnt_nxt > ae_ofs_q;
  assign paf_reg_n_o = paf_q;
  assign mode_o      = mode_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full_o && wr_en_i) |=> $stable(wptr_q)); // R3
  AST_WCOUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wptr_q - rbin) <= PW'(DEPTH)); // R3
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wgray_q ^ $past(wgray_q))); // R2
  AST_WMODE_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q)); // R7
endmodule

// File: rtl/tf_rd_ctl.sv
module tf_rd_ctl
  import tflag_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int AE_OFS = 7,
  parameter int AF_OFS = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_i,
  output logic          empty_o,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic          pae_set_o,
  output logic          paf_clr_o,
  output logic          pae_reg_n_o,
  output flag_mode_e    mode_o
);
  logic [PW-1:0] rptr_q, rgray_q, wbin, rptr_nxt, cnt_nxt, free_nxt;
  logic [PW-1:0] ae_ofs_q, af_ofs_q;
  logic          pae_q, pop;
  flag_mode_e    mode_q;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_i >> i);
    empty_o  = (wbin == rptr_q);
    pop      = rd_en_i && !empty_o;
    rptr_nxt = rptr_q + PW'(pop);
    cnt_nxt  = wbin - rptr_nxt;
    free_nxt = PW'(DEPTH) - cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q   <= '0;
      rgray_q  <= '0;
      pae_q    <= 1'b0;
      mode_q   <= flag_mode_e'(mode_i);
      ae_ofs_q <= PW'(AE_OFS);
      af_ofs_q <= PW'(AF_OFS);
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      pae_q   <= !(cnt_nxt <= ae_ofs_q);
    end
  end

  assign re_o        = pop;
  assign raddr_o     = rptr_q[AW-1:0];
  assign rgray_o     = rgray_q;
  assign pae_set_o   = cnt_nxt <= ae_ofs_q;
  assign paf_clr_o   = free_nxt > af_ofs_q;
  assign pae_reg_n_o = pae_q;
  assign mode_o      = mode_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty_o && rd_en_i) |=> $stable(rptr_q)); // R4
  AST_RCOUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wbin - rptr_q) <= PW'(DEPTH)); // R3
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgray_q ^ $past(rgray_q))); // R2
  AST_RMODE_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q)); // R7
endmodule

// File: rtl/tflag_fifo.sv
module tflag_fifo
  import tflag_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int W      = 36,
  parameter int AE_OFS = 7,
  parameter int AF_OFS = 7
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst,
  input  logic         flag_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         pae_n,
  output logic         paf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  logic [AW-1:0] waddr, raddr;
  logic          we, re;
  logic          paf_set, pae_clr, pae_set, paf_clr;
  logic          paf_reg_n, pae_reg_n, pae_split, paf_split;
  flag_mode_e    wmode, rmode;

  tf_wr_ctl #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_wr (
    .clk(wclk), .rst(mrst), .mode_i(flag_mode), .wr_en_i(wr_en),
    .rgray_i(rgray_ws), .full_o(full), .we_o(we), .waddr_o(waddr),
    .wgray_o(wgray), .paf_set_o(paf_set), .pae_clr_o(pae_clr),
    .paf_reg_n_o(paf_reg_n), .mode_o(wmode)
  );

  tf_rd_ctl #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_rd (
    .clk(rclk), .rst(mrst), .mode_i(flag_mode), .rd_en_i(rd_en),
    .wgray_i(wgray_rs), .empty_o(empty), .re_o(re), .raddr_o(raddr),
    .rgray_o(rgray), .pae_set_o(pae_set), .paf_clr_o(paf_clr),
    .pae_reg_n_o(pae_reg_n), .mode_o(rmode)
  );

  tf_sync #(.W(PW), .RST_VAL('0)) u_w2r (
    .clk(rclk), .rst(mrst), .d_i(wgray), .q_o(wgray_rs)
  );
  tf_sync #(.W(PW), .RST_VAL('0)) u_r2w (
    .clk(wclk), .rst(mrst), .d_i(rgray), .q_o(rgray_ws)
  );

  tf_ram #(.DEPTH(DEPTH), .W(W)) u_ram (
    .wclk(wclk), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data),
    .rclk(rclk), .re_i(re), .raddr_i(raddr), .rdata_o(rd_data)
  );

  // Nearly-empty: raised by the reader, withdrawn by the writer.
  tf_xflag #(.INIT_ACTIVE(1'b1)) u_ae (
    .s_clk(rclk), .s_rst(mrst), .s_cond_i(pae_set),
    .c_clk(wclk), .c_rst(mrst), .c_cond_i(pae_clr),
    .active_o(pae_split)
  );

  // Nearly-full: raised by the writer, withdrawn by the reader.
  tf_xflag #(.INIT_ACTIVE(1'b0)) u_af (
    .s_clk(wclk), .s_rst(mrst), .s_cond_i(paf_set),
    .c_clk(rclk), .c_rst(mrst), .c_cond_i(paf_clr),
    .active_o(paf_split)
  );

  assign pae_n = (rmode == FLAG_SINGLE) ? pae_reg_n : ~pae_split;
  assign paf_n = (wmode == FLAG_SINGLE) ? paf_reg_n : ~paf_split;
endmodule

// File: tb/test_tflag_fifo.sv
`timescale 1ns/100ps
module test_tflag_fifo;
  logic        wclk = 1'b0, rclk = 1'b0, mrst = 1'b1, flag_mode = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        full, empty, pae_n, paf_n;
  int          n_chk = 0, n_fail = 0;
  logic [35:0] got;

  always #2.5 wclk = ~wclk;   // 200 MHz write clock
  always #3.2 rclk = ~rclk;   // unrelated read clock

  tflag_fifo i_tflag_fifo (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .flag_mode(flag_mode),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .pae_n(pae_n), .paf_n(paf_n)
  );

  function automatic logic [35:0] pat(int i);
    return 36'hA_5000_0000 ^ 36'(i * 36'h0_0101_0103);
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic mode);
    @(posedge wclk); #1;
    mrst = 1'b1; flag_mode = mode; wr_en = 1'b0; rd_en = 1'b0;
    repeat (6) @(posedge rclk);
    @(posedge wclk); #1;
    mrst = 1'b0;
  endtask

  task automatic push(logic [35:0] d);
    @(posedge wclk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge wclk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [35:0] d);
    @(posedge rclk); #1;
    rd_en = 1'b1;
    @(posedge rclk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    #1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R1 empty", 36'(empty), 36'd1);
    chk("R1 full",  36'(full),  36'd0);
    chk("R1 pae_n", 36'(pae_n), 36'd0);
    chk("R1 paf_n", 36'(paf_n), 36'd1);
    do_reset(1'b1);
    chk("R1 pae_n single", 36'(pae_n), 36'd0);
    chk("R1 paf_n single", 36'(paf_n), 36'd1);
  endtask

  task automatic t_split_empty();
    do_reset(1'b0);
    for (int i = 0; i < 7; i++) push(pat(i));
    chk("R5 pae_n at count 7", 36'(pae_n), 36'd0);
    push(pat(7));
    chk("R8 pae_n rises on wclk edge", 36'(pae_n), 36'd1);
    settle();
    chk("R5 pae_n at count 8", 36'(pae_n), 36'd1);
    pop(got);
    chk("R2 first word", got, pat(0));
    chk("R8 pae_n falls on rclk edge", 36'(pae_n), 36'd0);
    for (int i = 1; i < 8; i++) begin
      pop(got);
      chk("R2 order", got, pat(i));
    end
    chk("R4 empty after drain", 36'(empty), 36'd1);
    pop(got);
    chk("R4 rd_data kept", got, pat(7));
    chk("R4 still empty", 36'(empty), 36'd1);
    push(36'h1_2345_6789);
    settle();
    pop(got);
    chk("R4 next word after dropped read", got, 36'h1_2345_6789);
  endtask

  task automatic t_split_full();
    do_reset(1'b0);
    for (int i = 0; i < 24; i++) push(pat(i));
    chk("R6 paf_n at free 8", 36'(paf_n), 36'd1);
    push(pat(24));
    chk("R8 paf_n falls on wclk edge", 36'(paf_n), 36'd0);
    for (int i = 25; i < 32; i++) push(pat(i));
    chk("R3 full at 32", 36'(full), 36'd1);
    push(36'hF_FFFF_FFFF);
    chk("R3 full after dropped write", 36'(full), 36'd1);
    settle();
    chk("R6 paf_n at free 0", 36'(paf_n), 36'd0);
    for (int i = 0; i < 7; i++) begin
      pop(got);
      chk("R3 stored word", got, pat(i));
    end
    chk("R6 paf_n at free 7", 36'(paf_n), 36'd0);
    pop(got);
    chk("R3 stored word", got, pat(7));
    chk("R8 paf_n rises on rclk edge", 36'(paf_n), 36'd1);
    for (int i = 8; i < 32; i++) begin
      pop(got);
      chk("R3 stored word", got, pat(i));
    end
    chk("R3 dropped word absent", 36'(empty), 36'd1);
  endtask

  task automatic t_single_domain();
    do_reset(1'b1);
    flag_mode = 1'b0;   // must be ignored after reset (R7)
    for (int i = 0; i < 8; i++) push(pat(i));
    chk("R7 R9 pae_n waits for read side", 36'(pae_n), 36'd0);
    settle();
    chk("R9 pae_n after crossing", 36'(pae_n), 36'd1);
    pop(got);
    chk("R9 pae_n falls on rclk", 36'(pae_n), 36'd0);
    settle();
    for (int i = 0; i < 17; i++) push(pat(100 + i));
    chk("R6 paf_n at count 24", 36'(paf_n), 36'd1);
    push(pat(117));
    chk("R9 paf_n falls on wclk", 36'(paf_n), 36'd0);
    settle();
    pop(got);
    chk("R2 single mode order", got, pat(1));
    chk("R9 paf_n waits for write side", 36'(paf_n), 36'd0);
    settle();
    chk("R9 paf_n after crossing", 36'(paf_n), 36'd1);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_split_empty();
    t_split_full();
    t_single_domain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule